// File: doc/BRIEF.md
# Banked Wishbone Host Control Bridge

This block sits between an external management bus and a chip's internal Wishbone fabric. It is a Wishbone slave that serves two kinds of access. When the top host address bit is 0, the access goes to a small local register file. When that bit is 1, the access is forwarded as an internal Wishbone cycle. The internal address is formed by placing the contents of a programmable bank register above the low host address bits. Software can therefore reach a wider internal space through a narrow window.

The same register file centralises chip-level housekeeping controls:
- six per-subsystem soft resets: Wishbone core, CPU, SPI, SDRAM, UART and I2C;
- a select that hands a set of shared pins either to the UART or to the I2C master;
- four divider selects, which produce divided clocks for the Wishbone, SDRAM, CPU and RTC domains;
- two words of 4-bit clock-skew control fields, which are only stored and exported.

The bridge path runs on its own reset input. It therefore stays usable while any of the soft resets it drives is held asserted.

A four-state machine sequences every host access:
- S_IDLE waits for cyc and stb. It moves to S_REG_ACK for a local access and to S_FWD_WAIT for a forwarded one.
- S_REG_ACK returns the acknowledge and goes back to S_IDLE.
- S_FWD_WAIT holds the internal cycle until the internal acknowledge arrives, then moves to S_FWD_ACK.
- S_FWD_ACK acknowledges the host and returns to S_IDLE.

Top module: `wbh_bank_bridge`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0x0000003F. All six active-low reset outputs are low, the pin select is 0 (UART), and the bank word (0x04) and both skew words (0x08, 0x0C) read 0.
- R2: Control word fields:
  - bit 0 holds the Wishbone core in reset; bit 1 the CPU; bit 2 SPI; bit 3 SDRAM; bit 4 UART; bit 5 I2C;
  - bit 7 is the pin select;
  - divider selects are [10:8] for Wishbone, [15:12] for SDRAM, [19:16] for CPU and [23:20] for RTC;
  - bits 6, 11 and [31:24] read as zero and ignore writes.
  Only bits [7:0] of the bank word are stored; the rest read as zero.
- R3: A register write updates only the bytes whose h_sel bit is 1 (h_sel[k] enables bits [8k+7:8k]).
- R4: When h_adr[LOW_AW] is 1, the bridge runs an internal cycle with m_adr = {bank[7:0], h_adr[LOW_AW-1:0]}, carrying we, sel and write data unchanged. It holds m_cyc, m_stb and m_adr steady until m_ack. It acknowledges the host on the cycle after m_ack, returning the internal read data (zero for writes).
- R5: Each reset output equals the inverse of its control bit. A 1 holds that subsystem in reset; a 0 releases it.
- R6: pin_sel_i2c follows control bit 7: 0 routes the shared pins to the UART, 1 to the I2C master.
- R7: A divider select of N gives a divided clock whose high and low phases each last N+1 input clock cycles.
- R8: A new divider select takes effect only at the start of the next divided-clock period. The period in progress completes with the old length, with no shortened phase.
- R9: Each skew word stores 28 bits ([27:0]) and exports them on skew_ctl_a / skew_ctl_b. Bits [31:28] read as zero.
- R10: A register-space access at any offset of 0x10 or above is acknowledged with zero read data, and a write there changes no register.
- R11: A local register access is acknowledged on the clock after the request is seen, with a one-cycle h_ack pulse. This holds while the Wishbone core reset bit is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low bridge reset |
| h_cyc | input | 1 | Host cycle |
| h_stb | input | 1 | Host strobe |
| h_we | input | 1 | Host write enable |
| h_adr | input | LOW_AW+1 | Host byte address; top bit selects forwarding |
| h_sel | input | 4 | Host byte enables |
| h_wdat | input | 32 | Host write data |
| h_rdat | output | 32 | Host read data |
| h_ack | output | 1 | Host acknowledge |
| m_cyc | output | 1 | Internal cycle |
| m_stb | output | 1 | Internal strobe |
| m_we | output | 1 | Internal write enable |
| m_adr | output | BANK_W+LOW_AW | Internal address, bank on top |
| m_sel | output | 4 | Internal byte enables |
| m_wdat | output | 32 | Internal write data |
| m_rdat | input | 32 | Internal read data |
| m_ack | input | 1 | Internal acknowledge |
| rst_wb_n | output | 1 | Wishbone core reset, active low |
| rst_cpu_n | output | 1 | CPU reset, active low |
| rst_spi_n | output | 1 | SPI reset, active low |
| rst_sdram_n | output | 1 | SDRAM reset, active low |
| rst_uart_n | output | 1 | UART reset, active low |
| rst_i2c_n | output | 1 | I2C reset, active low |
| pin_sel_i2c | output | 1 | Shared pin owner: 0 UART, 1 I2C |
| clk_wb_div | output | 1 | Divided Wishbone clock |
| clk_sdram_div | output | 1 | Divided SDRAM clock |
| clk_cpu_div | output | 1 | Divided CPU clock |
| clk_rtc_div | output | 1 | Divided RTC clock |
| skew_ctl_a | output | 28 | First skew-control word |
| skew_ctl_b | output | 28 | Second skew-control word |

## Verification
The bench builds the block with LOW_AW = 12 and BANK_W = 8, so forwarded internal addresses are 20 bits wide. With that width, bank placement and low-bit pass-through can be checked exactly in a short run. Divider selects of 0, 1, 2, 3 and 5 keep divided periods within a few dozen cycles, so high and low phase lengths are measured directly. A select change issued in the middle of a high phase shows whether the old period completes before the new length starts. Internal slave delays of one and three cycles show how the forward acknowledge tracks the internal acknowledge.

// File: rtl/wbh_bank_pkg.sv
package wbh_bank_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned SEL_W   = DATA_W / 8;
    localparam int unsigned NREGS   = 4;
    localparam int unsigned DIV_W   = 4;
    localparam int unsigned NDIV    = 4;

    // register indices (word offsets)
    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_BANK  = 1;
    localparam int unsigned IDX_SKEWA = 2;
    localparam int unsigned IDX_SKEWB = 3;

    // control word field positions
    localparam int unsigned B_RST_WB    = 0;
    localparam int unsigned B_RST_CPU   = 1;
    localparam int unsigned B_RST_SPI   = 2;
    localparam int unsigned B_RST_SDRAM = 3;
    localparam int unsigned B_RST_UART  = 4;
    localparam int unsigned B_RST_I2C   = 5;
    localparam int unsigned B_PIN_SEL   = 7;
    localparam int unsigned F_DIV_WB    = 8;   // 3 bits
    localparam int unsigned F_DIV_SDRAM = 12;  // 4 bits
    localparam int unsigned F_DIV_CPU   = 16;  // 4 bits
    localparam int unsigned F_DIV_RTC   = 20;  // 4 bits

    typedef enum logic [1:0] {
        S_IDLE,
        S_REG_ACK,
        S_FWD_WAIT,
        S_FWD_ACK
    } hb_state_e;

    // writable bits of each register
    function automatic logic [DATA_W-1:0] reg_mask(input int unsigned idx);
        logic [DATA_W-1:0] m;
        case (idx)
            IDX_CTRL: m = 32'h00FF_F7BF;
            IDX_BANK: m = 32'h0000_00FF;
            default:  m = 32'h0FFF_FFFF;
        endcase
        return m;
    endfunction

    // reset value: every soft reset asserted
    function automatic logic [DATA_W-1:0] reg_init(input int unsigned idx);
        return (idx == IDX_CTRL) ? 32'h0000_003F : '0;
    endfunction

endpackage

// File: rtl/wbh_reg_file.sv
module wbh_reg_file
    import wbh_bank_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic [SEL_W-1:0]          sel,
    input  logic [DATA_W-1:0]         wdat,
    output logic [DATA_W-1:0]         rdat,
    output logic [NREGS-1:0][DATA_W-1:0] regs
);

    logic [NREGS-1:0][DATA_W-1:0] regs_q;
    logic                         mapped;

    assign mapped = (idx < IDX_W'(NREGS));

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = reg_mask(r);
        localparam logic [DATA_W-1:0] INIT = reg_init(r);
        logic hit;
        assign hit = wr_en && mapped && (idx[1:0] == 2'(r));

        for (genvar b = 0; b < SEL_W; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[r][8*b +: 8] <= INIT[8*b +: 8];
                end else if (hit && sel[b]) begin
                    regs_q[r][8*b +: 8] <= wdat[8*b +: 8] & MASK[8*b +: 8];
                end
            end
        end
    end

    always_comb begin
        rdat = '0;
        if (mapped) begin
            rdat = regs_q[idx[1:0]];
        end
    end

    assign regs = regs_q;

    // R10: writes outside the map leave every register untouched
    a_r10_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=> $stable(regs_q));

    // R3: a write with no byte enables changes nothing
    a_r3_no_sel_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == '0)) |=> $stable(regs_q));

endmodule

// File: rtl/wbh_clk_div.sv
module wbh_clk_div
    import wbh_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             div_clk
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_q;
    logic             clk_q;
    logic             wrap;

    assign wrap = (cnt_q == lim_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
            clk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            clk_q <= ~clk_q;
            // new period starts at the low-to-high turn: pick up select here
            if (!clk_q) begin
                lim_q <= div_sel;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign div_clk = clk_q;

    // R8: the phase length only changes together with a rising divided edge
    a_r8_reload_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q != $past(lim_q)) |-> $rose(clk_q));

    // R7: the phase counter never runs past the active limit
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);

endmodule

// File: rtl/wbh_bus_fsm.sv
module wbh_bus_fsm
    import wbh_bank_pkg::*;
#(
    parameter int unsigned LOW_AW = 24,
    parameter int unsigned BANK_W = 8,
    localparam int unsigned INT_AW = BANK_W + LOW_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_cyc,
    input  logic              h_stb,
    input  logic              h_we,
    input  logic [LOW_AW:0]   h_adr,
    input  logic [SEL_W-1:0]  h_sel,
    input  logic [DATA_W-1:0] h_wdat,
    output logic [DATA_W-1:0] h_rdat,
    output logic              h_ack,
    output logic              m_cyc,
    output logic              m_stb,
    output logic              m_we,
    output logic [INT_AW-1:0] m_adr,
    output logic [SEL_W-1:0]  m_sel,
    output logic [DATA_W-1:0] m_wdat,
    input  logic [DATA_W-1:0] m_rdat,
    input  logic              m_ack,
    input  logic [BANK_W-1:0] bank,
    input  logic [DATA_W-1:0] reg_rdat,
    output logic              reg_wr
);

    hb_state_e state_q, state_d;
    logic      req;
    logic      fwd;

    logic [INT_AW-1:0] adr_q;
    logic              we_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;

    assign req = h_cyc && h_stb;
    assign fwd = h_adr[LOW_AW];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req) begin
                    state_d = fwd ? S_FWD_WAIT : S_REG_ACK;
                end
            end
            S_REG_ACK:  state_d = S_IDLE;
            S_FWD_WAIT: begin
                if (m_ack) begin
                    state_d = S_FWD_ACK;
                end
            end
            S_FWD_ACK:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        h_ack  = 1'b0;
        m_cyc  = 1'b0;
        m_stb  = 1'b0;
        reg_wr = 1'b0;
        unique case (state_q)
            S_IDLE:     reg_wr = req && !fwd && h_we;
            S_REG_ACK:  h_ack  = 1'b1;
            S_FWD_WAIT: begin
                m_cyc = 1'b1;
                m_stb = 1'b1;
            end
            S_FWD_ACK:  h_ack  = 1'b1;
        endcase
    end

    // captured request and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adr_q  <= '0;
            we_q   <= 1'b0;
            sel_q  <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            if (state_q == S_IDLE && req) begin
                if (fwd) begin
                    adr_q  <= {bank, h_adr[LOW_AW-1:0]};
                    we_q   <= h_we;
                    sel_q  <= h_sel;
                    wdat_q <= h_wdat;
                    rdat_q <= '0;
                end else begin
                    rdat_q <= h_we ? '0 : reg_rdat;
                end
            end else if (state_q == S_FWD_WAIT && m_ack && !we_q) begin
                rdat_q <= m_rdat;
            end
        end
    end

    assign m_adr  = adr_q;
    assign m_we   = we_q;
    assign m_sel  = sel_q;
    assign m_wdat = wdat_q;
    assign h_rdat = rdat_q;

    // R11: a local access is answered on the very next clock
    a_r11_reg_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && req && !fwd) |=> (h_ack && !m_cyc));

    // R11: acknowledge is a single-cycle pulse
    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        h_ack |=> !h_ack);

    // R4: internal request held steady until accepted
    a_r4_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc && !m_ack) |=> (m_cyc && m_stb && $stable(m_adr)));

    // R4: host acknowledge follows the internal acknowledge by one clock
    a_r4_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc && m_ack) |=> (h_ack && !m_cyc));

endmodule

// File: rtl/wbh_bank_bridge.sv
module wbh_bank_bridge
    import wbh_bank_pkg::*;
#(
    parameter int unsigned LOW_AW = 24,
    parameter int unsigned BANK_W = 8,
    localparam int unsigned INT_AW = BANK_W + LOW_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_cyc,
    input  logic              h_stb,
    input  logic              h_we,
    input  logic [LOW_AW:0]   h_adr,
    input  logic [3:0]        h_sel,
    input  logic [31:0]       h_wdat,
    output logic [31:0]       h_rdat,
    output logic              h_ack,
    output logic              m_cyc,
    output logic              m_stb,
    output logic              m_we,
    output logic [INT_AW-1:0] m_adr,
    output logic [3:0]        m_sel,
    output logic [31:0]       m_wdat,
    input  logic [31:0]       m_rdat,
    input  logic              m_ack,
    output logic              rst_wb_n,
    output logic              rst_cpu_n,
    output logic              rst_spi_n,
    output logic              rst_sdram_n,
    output logic              rst_uart_n,
    output logic              rst_i2c_n,
    output logic              pin_sel_i2c,
    output logic              clk_wb_div,
    output logic              clk_sdram_div,
    output logic              clk_cpu_div,
    output logic              clk_rtc_div,
    output logic [27:0]       skew_ctl_a,
    output logic [27:0]       skew_ctl_b
);

    localparam int unsigned IDX_W = LOW_AW - 2;

    logic [NREGS-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]            reg_rdat;
    logic                         reg_wr;
    logic [DATA_W-1:0]            ctrl;
    logic [NDIV-1:0][DIV_W-1:0]   div_sel;
    logic [NDIV-1:0]              div_clk;

    wbh_bus_fsm #(
        .LOW_AW (LOW_AW),
        .BANK_W (BANK_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_cyc    (h_cyc),
        .h_stb    (h_stb),
        .h_we     (h_we),
        .h_adr    (h_adr),
        .h_sel    (h_sel),
        .h_wdat   (h_wdat),
        .h_rdat   (h_rdat),
        .h_ack    (h_ack),
        .m_cyc    (m_cyc),
        .m_stb    (m_stb),
        .m_we     (m_we),
        .m_adr    (m_adr),
        .m_sel    (m_sel),
        .m_wdat   (m_wdat),
        .m_rdat   (m_rdat),
        .m_ack    (m_ack),
        .bank     (regs[IDX_BANK][BANK_W-1:0]),
        .reg_rdat (reg_rdat),
        .reg_wr   (reg_wr)
    );

    wbh_reg_file #(
        .IDX_W (IDX_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .idx   (h_adr[LOW_AW-1:2]),
        .sel   (h_sel),
        .wdat  (h_wdat),
        .rdat  (reg_rdat),
        .regs  (regs)
    );

    assign ctrl = regs[IDX_CTRL];

    assign rst_wb_n    = ~ctrl[B_RST_WB];
    assign rst_cpu_n   = ~ctrl[B_RST_CPU];
    assign rst_spi_n   = ~ctrl[B_RST_SPI];
    assign rst_sdram_n = ~ctrl[B_RST_SDRAM];
    assign rst_uart_n  = ~ctrl[B_RST_UART];
    assign rst_i2c_n   = ~ctrl[B_RST_I2C];
    assign pin_sel_i2c = ctrl[B_PIN_SEL];

    assign div_sel[0] = {1'b0, ctrl[F_DIV_WB +: 3]};
    assign div_sel[1] = ctrl[F_DIV_SDRAM +: DIV_W];
    assign div_sel[2] = ctrl[F_DIV_CPU +: DIV_W];
    assign div_sel[3] = ctrl[F_DIV_RTC +: DIV_W];

    for (genvar d = 0; d < NDIV; d++) begin : g_div
        wbh_clk_div u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .div_sel (div_sel[d]),
            .div_clk (div_clk[d])
        );
    end

    assign clk_wb_div    = div_clk[0];
    assign clk_sdram_div = div_clk[1];
    assign clk_cpu_div   = div_clk[2];
    assign clk_rtc_div   = div_clk[3];

    assign skew_ctl_a = regs[IDX_SKEWA][27:0];
    assign skew_ctl_b = regs[IDX_SKEWB][27:0];

    // R5: releasing a reset bit by a write shows on its output one clock later
    a_r5_cpu_release: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && h_adr[LOW_AW-1:2] == '0 && h_sel[0] && !h_wdat[B_RST_CPU]) |=> rst_cpu_n);

endmodule

// File: tb/wbh_bank_bridge_tb_top.sv
module wbh_bank_bridge_tb_top;

    localparam int unsigned LOW_AW = 12;
    localparam int unsigned BANK_W = 8;
    localparam int unsigned INT_AW = LOW_AW + BANK_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              h_cyc = 1'b0, h_stb = 1'b0, h_we = 1'b0;
    logic [LOW_AW:0]   h_adr = '0;
    logic [3:0]        h_sel = '0;
    logic [31:0]       h_wdat = '0;
    logic [31:0]       h_rdat;
    logic              h_ack;
    logic              m_cyc, m_stb, m_we;
    logic [INT_AW-1:0] m_adr;
    logic [3:0]        m_sel;
    logic [31:0]       m_wdat;
    logic [31:0]       m_rdat = '0;
    logic              m_ack = 1'b0;
    logic rst_wb_n, rst_cpu_n, rst_spi_n, rst_sdram_n, rst_uart_n, rst_i2c_n;
    logic pin_sel_i2c;
    logic clk_wb_div, clk_sdram_div, clk_cpu_div, clk_rtc_div;
    logic [27:0] skew_ctl_a, skew_ctl_b;
    logic [3:0]  divv;

    int checks = 0;
    int errors = 0;

    // internal slave model
    int                slv_delay = 1;
    int                slv_cnt = 0;
    logic [INT_AW-1:0] cap_adr = '0;
    logic              cap_we = 1'b0;
    logic [3:0]        cap_sel = '0;
    logic [31:0]       cap_wdat = '0;

    always #2 clk = ~clk;

    assign divv = {clk_rtc_div, clk_cpu_div, clk_sdram_div, clk_wb_div};

    wbh_bank_bridge #(.LOW_AW(LOW_AW), .BANK_W(BANK_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .h_cyc(h_cyc), .h_stb(h_stb), .h_we(h_we), .h_adr(h_adr), .h_sel(h_sel),
        .h_wdat(h_wdat), .h_rdat(h_rdat), .h_ack(h_ack),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr), .m_sel(m_sel),
        .m_wdat(m_wdat), .m_rdat(m_rdat), .m_ack(m_ack),
        .rst_wb_n(rst_wb_n), .rst_cpu_n(rst_cpu_n), .rst_spi_n(rst_spi_n),
        .rst_sdram_n(rst_sdram_n), .rst_uart_n(rst_uart_n), .rst_i2c_n(rst_i2c_n),
        .pin_sel_i2c(pin_sel_i2c),
        .clk_wb_div(clk_wb_div), .clk_sdram_div(clk_sdram_div),
        .clk_cpu_div(clk_cpu_div), .clk_rtc_div(clk_rtc_div),
        .skew_ctl_a(skew_ctl_a), .skew_ctl_b(skew_ctl_b)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (m_ack) begin
                m_ack = 1'b0;
                slv_cnt = 0;
            end else if (m_cyc && m_stb) begin
                slv_cnt++;
                if (slv_cnt == slv_delay) begin
                    cap_adr  = m_adr;
                    cap_we   = m_we;
                    cap_sel  = m_sel;
                    cap_wdat = m_wdat;
                    m_rdat   = 32'(m_adr) ^ 32'hC3A5_0000;
                    m_ack    = 1'b1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // caller is at a negedge; returns at the negedge where ack was seen
    task automatic access(input logic we, input logic [LOW_AW:0] adr, input logic [3:0] sel,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        h_cyc = 1'b1; h_stb = 1'b1; h_we = we; h_adr = adr; h_sel = sel; h_wdat = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!h_ack && lat < 50);
        rd = h_rdat;
        h_cyc = 1'b0; h_stb = 1'b0; h_we = 1'b0;
        @(negedge clk);
        check("R11 ack pulse", 32'(h_ack), 32'd0);
    endtask

    task automatic reg_wr(input logic [LOW_AW:0] adr, input logic [31:0] wd, input logic [3:0] sel);
        logic [31:0] rd; int lat;
        access(1'b1, adr, sel, wd, rd, lat);
        check("R11 write latency", 32'(lat), 32'd1);
    endtask

    task automatic reg_rd_chk(input string req, input logic [LOW_AW:0] adr, input logic [31:0] exp);
        logic [31:0] rd; int lat;
        access(1'b0, adr, 4'hF, 32'h0, rd, lat);
        check("R11 read latency", 32'(lat), 32'd1);
        check(req, rd, exp);
    endtask

    task automatic measure(input int idx, output int hi, output int lo);
        while (divv[idx]) @(negedge clk);
        while (!divv[idx]) @(negedge clk);
        hi = 0;
        while (divv[idx]) begin hi++; @(negedge clk); end
        lo = 0;
        while (!divv[idx]) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        check("R1 rst outputs low", 32'({rst_wb_n, rst_cpu_n, rst_spi_n, rst_sdram_n, rst_uart_n, rst_i2c_n}), 32'd0);
        check("R1 pin select uart", 32'(pin_sel_i2c), 32'd0);
        check("R1 skew ports", 32'(skew_ctl_a | skew_ctl_b), 32'd0);
        reg_rd_chk("R1 ctrl reset", 13'h000, 32'h0000_003F);
        reg_rd_chk("R1 bank reset", 13'h004, 32'h0);
        reg_rd_chk("R1 skew a reset", 13'h008, 32'h0);
        reg_rd_chk("R1 skew b reset", 13'h00C, 32'h0);
    endtask

    task automatic t_regs();
        reg_wr(13'h004, 32'hFFFF_FF5A, 4'hF);
        reg_rd_chk("R2 bank only low byte", 13'h004, 32'h0000_005A);
        reg_wr(13'h008, 32'hFFFF_FFFF, 4'hF);
        reg_rd_chk("R9 skew a top nibble zero", 13'h008, 32'h0FFF_FFFF);
        check("R9 skew a port", 32'(skew_ctl_a), 32'h0FFF_FFFF);
        reg_wr(13'h00C, 32'h1234_5678, 4'hF);
        reg_rd_chk("R9 skew b", 13'h00C, 32'h0234_5678);
        check("R9 skew b port", 32'(skew_ctl_b), 32'h0234_5678);
    endtask

    task automatic t_ctrl();
        reg_wr(13'h000, 32'hFFFF_FFFF, 4'hF);
        reg_rd_chk("R2 reserved bits zero", 13'h000, 32'h00FF_F7BF);
        check("R6 pin select i2c", 32'(pin_sel_i2c), 32'd1);
        reg_wr(13'h000, 32'h0, 4'hF);
        check("R5 all released", 32'({rst_wb_n, rst_cpu_n, rst_spi_n, rst_sdram_n, rst_uart_n, rst_i2c_n}), 32'h3F);
        check("R6 pin select uart", 32'(pin_sel_i2c), 32'd0);
        reg_wr(13'h000, 32'h0000_0015, 4'hF);
        check("R5 mixed resets", 32'({rst_wb_n, rst_cpu_n, rst_spi_n, rst_sdram_n, rst_uart_n, rst_i2c_n}), 32'b010101);
    endtask

    task automatic t_bytes();
        reg_wr(13'h000, 32'hAAAA_AAAA, 4'b0010);
        reg_rd_chk("R3 byte enable", 13'h000, 32'h0000_A215);
        reg_wr(13'h000, 32'h0000_0015, 4'b0010);
        reg_rd_chk("R3 byte restore", 13'h000, 32'h0000_0015);
    endtask

    task automatic t_unmapped();
        reg_rd_chk("R10 unmapped read zero", 13'h010, 32'h0);
        reg_wr(13'h020, 32'hFFFF_FFFF, 4'hF);
        reg_wr(13'h3FC, 32'hFFFF_FFFF, 4'hF);
        reg_rd_chk("R10 ctrl unchanged", 13'h000, 32'h0000_0015);
        reg_rd_chk("R10 bank unchanged", 13'h004, 32'h0000_005A);
        reg_rd_chk("R10 skew b unchanged", 13'h00C, 32'h0234_5678);
    endtask

    task automatic t_forward();
        logic [31:0] rd; int lat;
        // control has the wishbone core reset bit asserted here
        check("R11 wb reset held during fwd", 32'(rst_wb_n), 32'd0);
        slv_delay = 1;
        access(1'b0, {1'b1, 12'hABC}, 4'hF, 32'h0, rd, lat);
        check("R4 fwd addr", 32'(cap_adr), 32'h0005_AABC);
        check("R4 fwd read data", rd, 32'h0005_AABC ^ 32'hC3A5_0000);
        check("R4 fwd latency d1", 32'(lat), 32'd2);
        slv_delay = 3;
        access(1'b1, {1'b1, 12'h014}, 4'b0101, 32'hDEAD_BEEF, rd, lat);
        check("R4 fwd write addr", 32'(cap_adr), 32'h0005_A014);
        check("R4 fwd we", 32'(cap_we), 32'd1);
        check("R4 fwd sel", 32'(cap_sel), 32'h5);
        check("R4 fwd wdat", cap_wdat, 32'hDEAD_BEEF);
        check("R4 fwd write rdata zero", rd, 32'h0);
        check("R4 fwd latency d3", 32'(lat), 32'd4);
        reg_wr(13'h004, 32'h0000_00C1, 4'h1);
        slv_delay = 1;
        access(1'b0, {1'b1, 12'h000}, 4'hF, 32'h0, rd, lat);
        check("R4 new bank", 32'(cap_adr), 32'h000C_1000);
    endtask

    task automatic t_div();
        int hi, lo;
        // wb=2, sdram=5, cpu=0, rtc=1, keep resets 0x15
        reg_wr(13'h000, (32'd1 << 20) | (32'd0 << 16) | (32'd5 << 12) | (32'd2 << 8) | 32'h15, 4'hF);
        repeat (40) @(negedge clk);
        measure(0, hi, lo);
        check("R7 wb high", 32'(hi), 32'd3);
        check("R7 wb low", 32'(lo), 32'd3);
        measure(1, hi, lo);
        check("R7 sdram high", 32'(hi), 32'd6);
        check("R7 sdram low", 32'(lo), 32'd6);
        measure(2, hi, lo);
        check("R7 cpu high", 32'(hi), 32'd1);
        check("R7 cpu low", 32'(lo), 32'd1);
        measure(3, hi, lo);
        check("R7 rtc high", 32'(hi), 32'd2);
        check("R7 rtc low", 32'(lo), 32'd2);
    endtask

    task automatic t_div_change();
        int hi, lo, hi2, lo2;
        reg_wr(13'h000, (32'd3 << 16) | 32'h15, 4'hF);
        measure(2, hi, lo);
        measure(2, hi, lo);
        check("R8 settled high", 32'(hi), 32'd4);
        while (clk_cpu_div) @(negedge clk);
        while (!clk_cpu_div) @(negedge clk);
        fork
            reg_wr(13'h000, (32'd1 << 16) | 32'h15, 4'hF);
            begin
                hi = 0;
                while (clk_cpu_div) begin hi++; @(negedge clk); end
                lo = 0;
                while (!clk_cpu_div) begin lo++; @(negedge clk); end
                hi2 = 0;
                while (clk_cpu_div) begin hi2++; @(negedge clk); end
                lo2 = 0;
                while (!clk_cpu_div) begin lo2++; @(negedge clk); end
            end
        join
        check("R8 old high kept", 32'(hi), 32'd4);
        check("R8 old low kept", 32'(lo), 32'd4);
        check("R8 new high", 32'(hi2), 32'd2);
        check("R8 new low", 32'(lo2), 32'd2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_ctrl();
        t_bytes();
        t_unmapped();
        t_forward();
        t_div();
        t_div_change();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule